// File: doc/BRIEF.md
# SDRAM Read Data Return Scheduler

This block sits beside an SDRAM command issuer and decides, for every READ it accepts, in which cycles the read data comes back on the memory data bus. Each READ carries a bank number, a starting column and an auto-precharge flag. The block delays the READ by the CAS latency and then walks through a burst of beats. For each beat it presents a valid flag, the beat number within the burst, the column that beat belongs to and the bank. Capture logic downstream uses these to tag the data words it samples from the bus.

Columns follow the sequential burst order. The low bits count up from the starting column and wrap inside a block aligned to the burst length, while the upper bits stay fixed. READs spaced one burst length apart, usually to different banks, give back-to-back bursts with no idle cycle between them. A READ that arrives earlier cuts the running burst short, and its beats win from their first cycle. When the auto-precharge flag is set, a one-cycle pulse naming the bank marks the cycle in which the internal precharge of that bank begins, one burst length after the READ.

The beat outputs form a stream with a valid flag and no ready. The SDRAM places data on the bus at a fixed latency that cannot be held back, so a consumer must accept every beat in the cycle it is flagged. CAS latency (2 or 3) and burst length (1, 2, 4 or 8) are parameters. The bank field is 2 bits and the column field is 8 bits.

Top module: `sdr_rdsched`

## Requirements
- R1: A READ sampled in cycle t makes beat_valid high in cycle t+CAS_LAT, with beat_idx 0, beat_col equal to the READ's column and beat_bank equal to its bank.
- R2: Without a later READ, a burst shows beat_valid high for exactly BURST_LEN consecutive cycles with beat_idx counting 0, 1, … BURST_LEN-1, and beat_valid then falls.
- R3: For beat i, beat_col keeps the starting column's bits above bit log2(BURST_LEN) and sets the low log2(BURST_LEN) bits to (start low bits + i) mod BURST_LEN.
- R4: READs sampled exactly BURST_LEN cycles apart give beat_valid high without a gap from the first beat of the first READ to the last beat of the last READ.
- R5: A READ sampled fewer than BURST_LEN cycles after the previous one ends the earlier burst: from the newer READ's first beat cycle on, only the newer READ's beats appear, starting at beat_idx 0.
- R6: A READ with rd_ap high sampled in cycle t makes ap_start high for exactly one cycle, cycle t+BURST_LEN, with ap_bank equal to that READ's bank.
- R7: ap_start is high only in cycles that lie BURST_LEN cycles after a READ sampled with rd_ap high; a READ with rd_ap low causes no pulse.
- R8: While rst_n is low, and after reset until the first READ takes effect, beat_valid and ap_start are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | READ command accepted in this cycle |
| rd_bank | input | 2 | Bank of the READ |
| rd_col | input | 8 | Starting column of the READ |
| rd_ap | input | 1 | Auto-precharge requested with the READ |
| beat_valid | output | 1 | A read data beat is on the bus in this cycle |
| beat_idx | output | max(1, log2(BURST_LEN)) | Position of the beat in its burst |
| beat_col | output | 8 | Column address of the beat |
| beat_bank | output | 2 | Bank of the beat |
| ap_start | output | 1 | Internal auto-precharge starts in this cycle |
| ap_bank | output | 2 | Bank whose auto-precharge starts |

## Verification
Two of the block's functions can act in the same cycle. One is launching a new burst, which must win over a burst still running. The other is the auto-precharge pulse of an earlier READ, which lands in the middle of beat traffic. The bench sweeps the spacing of a READ pair from one cycle up to past the burst length, with auto-precharge set on both, so that a launch, a truncation and a pulse fall into shared cycles. Every cycle, the beat fields and the pulse are compared with a per-cycle expectation. Expected values are built arithmetically, and a newer READ overwrites the expected beats of an older one from its first beat onward.

// File: rtl/sdr_rdsched_pkg.sv
package sdr_rdsched_pkg;

  localparam int BANK_W = 2;
  localparam int COL_W  = 8;

  typedef struct packed {
    logic              ap;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } rd_cmd_t;

  function automatic int idx_width(input int blen);
    return (blen > 1) ? $clog2(blen) : 1;
  endfunction

endpackage

// File: rtl/sdr_rdsched_lat_pipe.sv
module sdr_rdsched_lat_pipe
  import sdr_rdsched_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_vld,
  input  rd_cmd_t in_cmd,
  output logic    out_vld,
  output rd_cmd_t out_cmd
);

  logic [DEPTH-1:0] vld_q;
  rd_cmd_t          cmd_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q[0] <= in_vld;
      for (int s = 1; s < DEPTH; s++) begin
        vld_q[s] <= vld_q[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    cmd_q[0] <= in_cmd;
    for (int s = 1; s < DEPTH; s++) begin
      cmd_q[s] <= cmd_q[s-1];
    end
  end

  assign out_vld = vld_q[DEPTH-1];
  assign out_cmd = cmd_q[DEPTH-1];

endmodule

// File: rtl/sdr_rdsched_burst.sv
module sdr_rdsched_burst
  import sdr_rdsched_pkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int IDX_W    = idx_width(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [BANK_W-1:0] launch_bank,
  input  logic [COL_W-1:0]  launch_col,
  output logic              beat_valid,
  output logic [IDX_W-1:0]  beat_idx,
  output logic [COL_W-1:0]  beat_col,
  output logic [BANK_W-1:0] beat_bank
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

  logic              act_q;
  logic [IDX_W-1:0]  idx_q;
  logic [COL_W-1:0]  start_q;
  logic [BANK_W-1:0] bank_q;

  // A launch always restarts the counter, so a newer READ cuts the old burst.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (launch) begin
      act_q <= 1'b1;
      idx_q <= '0;
    end else if (act_q) begin
      if (idx_q == LAST_IDX) begin
        act_q <= 1'b0;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (launch) begin
      start_q <= launch_col;
      bank_q  <= launch_bank;
    end
  end

  generate
    if (BURST_LEN == 1) begin : g_single
      assign beat_col = start_q;
    end else begin : g_wrap
      logic [IDX_W-1:0] low_col;
      assign low_col  = start_q[IDX_W-1:0] + idx_q;
      assign beat_col = {start_q[COL_W-1:IDX_W], low_col};
    end
  endgenerate

  assign beat_valid = act_q;
  assign beat_idx   = idx_q;
  assign beat_bank  = bank_q;

endmodule

// File: rtl/sdr_rdsched_ap_delay.sv
module sdr_rdsched_ap_delay
  import sdr_rdsched_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic [BANK_W-1:0] in_bank,
  output logic              out_fire,
  output logic [BANK_W-1:0] out_bank
);

  logic [DEPTH-1:0]  fire_q;
  logic [BANK_W-1:0] bank_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= '0;
    end else begin
      fire_q[0] <= in_fire;
      for (int s = 1; s < DEPTH; s++) begin
        fire_q[s] <= fire_q[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    bank_q[0] <= in_bank;
    for (int s = 1; s < DEPTH; s++) begin
      bank_q[s] <= bank_q[s-1];
    end
  end

  assign out_fire = fire_q[DEPTH-1];
  assign out_bank = bank_q[DEPTH-1];

endmodule

// File: rtl/sdr_rdsched.sv
module sdr_rdsched
  import sdr_rdsched_pkg::*;
#(
  parameter int  CAS_LAT   = 3,
  parameter int  BURST_LEN = 4,
  localparam int IDX_W     = idx_width(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  input  logic              rd_ap,
  output logic              beat_valid,
  output logic [IDX_W-1:0]  beat_idx,
  output logic [COL_W-1:0]  beat_col,
  output logic [BANK_W-1:0] beat_bank,
  output logic              ap_start,
  output logic [BANK_W-1:0] ap_bank
);

  // The burst engine adds one register, so the pipe holds CAS_LAT-1 stages.
  localparam int PIPE_DEPTH = CAS_LAT - 1;

  rd_cmd_t in_cmd;
  rd_cmd_t lat_cmd;
  logic    lat_vld;

  assign in_cmd = '{ap: rd_ap, bank: rd_bank, col: rd_col};

  sdr_rdsched_lat_pipe #(
    .DEPTH (PIPE_DEPTH)
  ) lat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (rd_req),
    .in_cmd  (in_cmd),
    .out_vld (lat_vld),
    .out_cmd (lat_cmd)
  );

  logic lat_ap_unused;
  assign lat_ap_unused = lat_cmd.ap;

  sdr_rdsched_burst #(
    .BURST_LEN (BURST_LEN)
  ) burst_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (lat_vld),
    .launch_bank (lat_cmd.bank),
    .launch_col  (lat_cmd.col),
    .beat_valid  (beat_valid),
    .beat_idx    (beat_idx),
    .beat_col    (beat_col),
    .beat_bank   (beat_bank)
  );

  sdr_rdsched_ap_delay #(
    .DEPTH (BURST_LEN)
  ) ap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fire  (rd_req & rd_ap),
    .in_bank  (rd_bank),
    .out_fire (ap_start),
    .out_bank (ap_bank)
  );

endmodule

// File: rtl/sdr_rdsched_chk.sv
module sdr_rdsched_chk
  import sdr_rdsched_pkg::*;
#(
  parameter int  CAS_LAT   = 3,
  parameter int  BURST_LEN = 4,
  localparam int IDX_W     = idx_width(BURST_LEN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic [BANK_W-1:0] rd_bank,
  input logic [COL_W-1:0]  rd_col,
  input logic              rd_ap,
  input logic              beat_valid,
  input logic [IDX_W-1:0]  beat_idx,
  input logic [COL_W-1:0]  beat_col,
  input logic [BANK_W-1:0] beat_bank,
  input logic              ap_start,
  input logic [BANK_W-1:0] ap_bank
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);
  localparam logic [COL_W-1:0] LOW_MASK = COL_W'(BURST_LEN - 1);

  assert_first_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_req, CAS_LAT) && $past(rst_n, CAS_LAT)) |->
      (beat_valid && beat_idx == '0 && beat_col == $past(rd_col, CAS_LAT)
       && beat_bank == $past(rd_bank, CAS_LAT)));

  assert_beats_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_idx != LAST_IDX) |=> beat_valid);

  assert_burst_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_idx == LAST_IDX && !$past(rd_req, CAS_LAT - 1)) |=> !beat_valid);

  assert_col_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid) && beat_idx != '0) |->
      (((beat_col ^ $past(beat_col)) & ~LOW_MASK) == '0
       && ((beat_col - $past(beat_col)) & LOW_MASK) == COL_W'(1)));

  assert_newest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_req, CAS_LAT) && $past(rst_n, CAS_LAT) && $past(beat_valid)) |->
      (beat_idx == '0));

  assert_ap_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_req && rd_ap, BURST_LEN) && $past(rst_n, BURST_LEN)) |->
      (ap_start && ap_bank == $past(rd_bank, BURST_LEN)));

  assert_ap_only_when_asked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ap_start |-> $past(rd_req && rd_ap, BURST_LEN));

endmodule

bind sdr_rdsched sdr_rdsched_chk #(
  .CAS_LAT   (CAS_LAT),
  .BURST_LEN (BURST_LEN)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .rd_bank    (rd_bank),
  .rd_col     (rd_col),
  .rd_ap      (rd_ap),
  .beat_valid (beat_valid),
  .beat_idx   (beat_idx),
  .beat_col   (beat_col),
  .beat_bank  (beat_bank),
  .ap_start   (ap_start),
  .ap_bank    (ap_bank)
);

// File: tb/sdr_rdsched_tb_top.sv
`timescale 1ns/1ps
module sdr_rdsched_tb_top;

  localparam int CL = 3;
  localparam int BL = 4;
  localparam int IW = 2;
  localparam int N  = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_req;
  logic [1:0] rd_bank;
  logic [7:0] rd_col;
  logic       rd_ap;
  logic       beat_valid;
  logic [IW-1:0] beat_idx;
  logic [7:0] beat_col;
  logic [1:0] beat_bank;
  logic       ap_start;
  logic [1:0] ap_bank;

  always #2.5 clk = ~clk;

  sdr_rdsched #(.CAS_LAT(CL), .BURST_LEN(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_bank(rd_bank),
    .rd_col(rd_col), .rd_ap(rd_ap), .beat_valid(beat_valid),
    .beat_idx(beat_idx), .beat_col(beat_col), .beat_bank(beat_bank),
    .ap_start(ap_start), .ap_bank(ap_bank)
  );

  int errs   = 0;
  int checks = 0;

  int p_v[N], p_bank[N], p_col[N], p_ap[N];
  int e_v[N], e_idx[N], e_col[N], e_bank[N], e_ap[N], e_apb[N];

  task automatic clear_plan();
    for (int i = 0; i < N; i++) begin
      p_v[i] = 0; p_bank[i] = 0; p_col[i] = 0; p_ap[i] = 0;
      e_v[i] = 0; e_idx[i] = 0; e_col[i] = 0; e_bank[i] = 0;
      e_ap[i] = 0; e_apb[i] = 0;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int wrap_col(input int start, input int i);
    return (start & ~(BL - 1) & 255) | ((start + i) & (BL - 1));
  endfunction

  // One pass over a planned scenario; cycle c is checked, then driven.
  task automatic run(input string tag, input int len);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      chk({tag, " R2"}, "beat_valid", int'(beat_valid), e_v[c]);
      if (e_v[c] != 0) begin
        chk({tag, " R2"}, "beat_idx", int'(beat_idx), e_idx[c]);
        chk({tag, " R3"}, "beat_col", int'(beat_col), e_col[c]);
        chk({tag, " R1"}, "beat_bank", int'(beat_bank), e_bank[c]);
      end
      chk({tag, " R7"}, "ap_start", int'(ap_start), e_ap[c]);
      if (e_ap[c] != 0) chk({tag, " R6"}, "ap_bank", int'(ap_bank), e_apb[c]);
      rd_req  = (p_v[c] != 0);
      rd_bank = 2'(p_bank[c]);
      rd_col  = 8'(p_col[c]);
      rd_ap   = (p_ap[c] != 0);
      if (p_v[c] != 0) begin
        for (int i = 0; i < BL; i++) begin
          if (c + CL + i < N) begin
            e_v[c+CL+i]    = 1;
            e_idx[c+CL+i]  = i;
            e_col[c+CL+i]  = wrap_col(p_col[c], i);
            e_bank[c+CL+i] = p_bank[c];
          end
        end
        if (p_ap[c] != 0 && c + BL < N) begin
          e_ap[c+BL]  = 1;
          e_apb[c+BL] = p_bank[c];
        end
      end
    end
    rd_req = 1'b0;
    rd_ap  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_req = 1'b0; rd_bank = '0; rd_col = '0; rd_ap = 1'b0;
    // R8: outputs quiet in reset and just after it
    repeat (3) begin
      @(negedge clk);
      chk("R8", "beat_valid in reset", int'(beat_valid), 0);
      chk("R8", "ap_start in reset", int'(ap_start), 0);
    end
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R8", "beat_valid after reset", int'(beat_valid), 0);
      chk("R8", "ap_start after reset", int'(ap_start), 0);
    end

    // R1 R3 R6 R7: single READs over start columns, banks and the ap flag
    for (int s = 0; s < 16; s++) begin
      clear_plan();
      p_v[0] = 1; p_col[0] = (s * 37 + s) & 255; p_bank[0] = s % 4; p_ap[0] = s % 2;
      run((s % 2) != 0 ? "R6" : "R7", 14);
    end

    // R5 R4: READ pairs at every spacing, both with auto-precharge
    for (int g = 1; g <= BL + 2; g++) begin
      clear_plan();
      p_v[0] = 1; p_col[0] = 8'hF2; p_bank[0] = 0; p_ap[0] = 1;
      p_v[g] = 1; p_col[g] = 8'h41; p_bank[g] = 1; p_ap[g] = 1;
      run(g < BL ? "R5" : (g == BL ? "R4" : "R2"), 20);
    end

    // R4: stream of READs one burst apart across rotating banks
    clear_plan();
    for (int k = 0; k < 6; k++) begin
      p_v[k*BL] = 1; p_col[k*BL] = (k * 53 + 3) & 255;
      p_bank[k*BL] = k % 4; p_ap[k*BL] = k % 2;
    end
    run("R4", 6 * BL + CL + BL + 3);

    // R5: READs on every cycle, each cutting the one before
    clear_plan();
    for (int k = 0; k < 5; k++) begin
      p_v[k] = 1; p_col[k] = 8'h10 + k * 5; p_bank[k] = (k + 2) % 4; p_ap[k] = 1;
    end
    run("R5", 5 + CL + BL + 3);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule